// File: doc/BRIEF.md
# Single-Phase Multilevel Level Modulator

This block drives one phase of an N-level power converter. Once per switching period it turns a signed reference voltage into a positive level index. It does this by adding the largest phase voltage and dividing by the voltage step between adjacent levels. It splits the index into an integer part and a fraction. For the first part of the period it outputs the lower of the two nearest levels, and for the remainder it outputs the next level up. The share of the period spent on each level follows the fraction. No carrier comparison and no vector search are involved, so the logic stays the same size for any level count.

The output is a plain level index for a topology-specific gate-signal generator. A programmable count of clock cycles sets the switching period. At 125 MHz, periods from 500 Hz to 2.5 kHz and beyond fit the default counter width. All inputs are captured together on the last clock of a period. A sequential divider works on them during the following period, and the result drives the period after that. Because of this, one period never mixes two references.

Top module: `lvlmod_top`

## Requirements
- R1: With 8 fraction bits, the plan of a period comes from q = floor((vref + vmax) * 256 / step). The lower level is q / 256 and the fraction is r = q mod 256. All values are integers in the same voltage units.
- R2: During a P-clock period, level_out equals the lower level for the first D = floor(((256 - r) * P + 128) / 256) clocks, which is the dwell rounded half up. For the other P - D clocks it equals the lower level plus one.
- R3: When vref + vmax is negative, level_out is 0 for the whole period.
- R4: When vref + vmax >= step * (N - 1), level_out is N - 1 (4 for the default N = 5) for the whole period. This includes a reference exactly on the top level and a step of zero.
- R5: The inputs present on the last clock of a period set the level plan and the length of the period after the next one.
- R6: A period lasts max(period_in, 13) clocks, where 13 is the minimum for the default widths. period_start_out is 1 on exactly the first clock of each period.
- R7: While rst_n is low, level_out is 0 and period_start_out is 1. The first two periods after reset last 13 clocks each at level 0.
- R8: A reference that lands exactly on a level (r = 0) holds that level for the full period.
- R9: Input changes on any clock other than the last clock of a period have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vref_in | input | REF_W | Signed reference voltage |
| step_in | input | REF_W | Voltage between adjacent levels, unsigned |
| vmax_in | input | REF_W | Largest phase voltage, unsigned |
| period_in | input | PER_W | Switching period in clocks |
| level_out | output | clog2(LEVELS) | Level index for the gate-signal generator |
| period_start_out | output | 1 | High on the first clock of each period |

## Verification
The hardest situation to reach from the ports is a change of reference that arrives in the middle of a period. The capture point is a single clock, and a fault that samples one clock early or late only shows when the inputs differ on exactly those clocks. The stimulus therefore redraws the reference on every clock over many periods while the model tracks only the values present on each period's last clock. Separate segments aim at the edges of the arithmetic: a sum just below and exactly at the top level, a zero step, negative sums, and fractions that round the upper dwell to nothing.

// File: rtl/lvlmod_pkg.sv
package lvlmod_pkg;

  // Range class of a sampled reference, decided before the divide
  typedef enum logic [1:0] {
    RNG_NORMAL = 2'd0,
    RNG_FLOOR  = 2'd1,
    RNG_CEIL   = 2'd2
  } range_e;

endpackage

// File: rtl/lvlmod_timer.sv
module lvlmod_timer #(
  parameter int PER_W   = 18,
  parameter int MIN_PER = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] len_next,
  output logic [PER_W-1:0] cnt,
  output logic             wrap
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] len_q, len_d;

  assign wrap = (cnt_q == len_q - 1'b1);
  assign cnt  = cnt_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    len_d = len_q;
    if (wrap) begin
      cnt_d = '0;
      len_d = len_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= PER_W'(MIN_PER);
    end else begin
      cnt_q <= cnt_d;
      if (wrap) len_q <= len_d;
    end
  end

  // R6: the count stays inside the current period
  assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  // R6: a period never drops below the floor
  assert_period_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= PER_W'(MIN_PER));

endmodule

// File: rtl/lvlmod_div.sv
module lvlmod_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 16,
  parameter int QW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num_in,
  input  logic [DEN_W-1:0] den_in,
  output logic             busy,
  output logic             done,
  output logic [QW-1:0]    quo
);

  localparam int SW = $clog2(QW + 1);

  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [QW-1:0]    sh_q, sh_d;
  logic [SW-1:0]    step_q, step_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   rem_try;
  logic [DEN_W:0]   rem_sub;
  logic             fits;

  always_comb begin
    rem_try = {rem_q, sh_q[QW-1]};
    rem_sub = rem_try - {1'b0, den_q};
    fits    = (rem_try >= {1'b0, den_q});
    rem_d   = rem_q;
    den_d   = den_q;
    sh_d    = sh_q;
    step_d  = step_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (start) begin
      rem_d  = DEN_W'(num_in[NUM_W-1:QW]);
      sh_d   = num_in[QW-1:0];
      den_d  = den_in;
      step_d = SW'(QW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = fits ? rem_sub[DEN_W-1:0] : rem_try[DEN_W-1:0];
      sh_d   = {sh_q[QW-2:0], fits};
      step_d = step_q - 1'b1;
      if (step_q == SW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      sh_q   <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      sh_q   <= sh_d;
      step_q <= step_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = sh_q;

  // R1: a result is only flagged at the end of a running divide
  assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

endmodule

// File: rtl/lvlmod_dwell.sv
module lvlmod_dwell #(
  parameter int FRAC_W = 8,
  parameter int PER_W  = 18
) (
  input  logic [FRAC_W-1:0] frac,
  input  logic [PER_W-1:0]  per,
  output logic [PER_W-1:0]  dwell
);

  localparam int PW = FRAC_W + 1 + PER_W;

  logic [FRAC_W:0] keep;
  logic [PW-1:0]   prod;

  always_comb begin
    keep  = (FRAC_W+1)'(1 << FRAC_W) - {1'b0, frac};
    prod  = PW'(keep) * PW'(per) + PW'(1 << (FRAC_W - 1));
    dwell = prod[FRAC_W +: PER_W];
  end

endmodule

// File: rtl/lvlmod_top.sv
module lvlmod_top
  import lvlmod_pkg::*;
#(
  parameter int REF_W  = 16,
  parameter int LEVELS = 5,
  parameter int FRAC_W = 8,
  parameter int PER_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [REF_W-1:0]  vref_in,
  input  logic [REF_W-1:0]         step_in,
  input  logic [REF_W-1:0]         vmax_in,
  input  logic [PER_W-1:0]         period_in,
  output logic [$clog2(LEVELS)-1:0] level_out,
  output logic                     period_start_out
);

  localparam int LVL_W   = $clog2(LEVELS);
  localparam int QW      = LVL_W + FRAC_W;
  localparam int NUM_W   = REF_W + 1 + FRAC_W;
  localparam int SUM_W   = REF_W + 2;
  localparam int CEIL_W  = REF_W + LVL_W;
  localparam int MIN_PER = QW + 2;
  localparam int TOP     = LEVELS - 1;

  // capture-side arithmetic
  logic signed [SUM_W-1:0] sum_c;
  logic [CEIL_W-1:0]       ceil_c;
  logic [NUM_W-1:0]        dvd_c;
  range_e                  rng_c;
  logic [PER_W-1:0]        per_c;

  always_comb begin
    sum_c  = SUM_W'(vref_in) + $signed({2'b00, vmax_in});
    ceil_c = CEIL_W'(step_in) * CEIL_W'(TOP);
    dvd_c  = {sum_c[REF_W:0], FRAC_W'(0)};
    per_c  = (period_in < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : period_in;
    if (sum_c[SUM_W-1])
      rng_c = RNG_FLOOR;
    else if ((CEIL_W+1)'(sum_c[REF_W:0]) >= {1'b0, ceil_c})
      rng_c = RNG_CEIL;
    else
      rng_c = RNG_NORMAL;
  end

  // period timer
  logic [PER_W-1:0] cnt;
  logic             wrap;
  logic [PER_W-1:0] pend_per_q;

  lvlmod_timer #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_next (pend_per_q),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  // sampled inputs, held while the divide runs
  range_e           smp_rng_q;
  logic [PER_W-1:0] smp_per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_rng_q <= RNG_FLOOR;
      smp_per_q <= PER_W'(MIN_PER);
    end else if (wrap) begin
      smp_rng_q <= rng_c;
      smp_per_q <= per_c;
    end
  end

  logic          div_busy;
  logic          div_done;
  logic [QW-1:0] div_quo;

  lvlmod_div #(.NUM_W(NUM_W), .DEN_W(REF_W), .QW(QW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wrap),
    .num_in (dvd_c),
    .den_in (step_in),
    .busy   (div_busy),
    .done   (div_done),
    .quo    (div_quo)
  );

  // plan for the next period
  logic [LVL_W-1:0]  plan_lo_c;
  logic [FRAC_W-1:0] plan_frac_c;
  logic [PER_W-1:0]  plan_dwell_c;

  always_comb begin
    unique case (smp_rng_q)
      RNG_FLOOR: begin
        plan_lo_c   = '0;
        plan_frac_c = '0;
      end
      RNG_CEIL: begin
        plan_lo_c   = LVL_W'(TOP);
        plan_frac_c = '0;
      end
      default: begin
        plan_lo_c   = div_quo[QW-1:FRAC_W];
        plan_frac_c = div_quo[FRAC_W-1:0];
      end
    endcase
  end

  lvlmod_dwell #(.FRAC_W(FRAC_W), .PER_W(PER_W)) u_dwell (
    .frac  (plan_frac_c),
    .per   (smp_per_q),
    .dwell (plan_dwell_c)
  );

  logic [LVL_W-1:0] pend_lo_q;
  logic [PER_W-1:0] pend_dwell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lo_q    <= '0;
      pend_dwell_q <= PER_W'(MIN_PER);
      pend_per_q   <= PER_W'(MIN_PER);
    end else if (div_done) begin
      pend_lo_q    <= plan_lo_c;
      pend_dwell_q <= plan_dwell_c;
      pend_per_q   <= smp_per_q;
    end
  end

  // plan in force for the running period
  logic [LVL_W-1:0] act_lo_q;
  logic [PER_W-1:0] act_dwell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo_q    <= '0;
      act_dwell_q <= PER_W'(MIN_PER);
    end else if (wrap) begin
      act_lo_q    <= pend_lo_q;
      act_dwell_q <= pend_dwell_q;
    end
  end

  assign level_out        = (cnt < act_dwell_q) ? act_lo_q : act_lo_q + 1'b1;
  assign period_start_out = (cnt == '0);

  // R4: the index never leaves the level range
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_out <= LVL_W'(TOP));

  // R4: a top-level plan never steps above itself
  assert_top_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lo_q == LVL_W'(TOP)) |-> (level_out == LVL_W'(TOP)));

  // R2: inside a period the level only steps once, upward by one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start_out && level_out != $past(level_out))
      |-> (level_out == $past(level_out) + 1'b1));

  // R5: the next capture never lands on a divide still in flight
  assert_div_idle_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> !div_busy);

endmodule

// File: tb/lvlmod_top_test.sv
`timescale 1ns/1ps
module lvlmod_top_test;

  localparam int REF_W   = 16;
  localparam int LEVELS  = 5;
  localparam int FRAC_W  = 8;
  localparam int PER_W   = 18;
  localparam int LVL_W   = 3;
  localparam int MIN_PER = 13;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic signed [REF_W-1:0]  vref_in;
  logic [REF_W-1:0]         step_in;
  logic [REF_W-1:0]         vmax_in;
  logic [PER_W-1:0]         period_in;
  logic [LVL_W-1:0]         level_out;
  logic                     period_start_out;

  lvlmod_top #(.REF_W(REF_W), .LEVELS(LEVELS), .FRAC_W(FRAC_W), .PER_W(PER_W)) uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .vref_in          (vref_in),
    .step_in          (step_in),
    .vmax_in          (vmax_in),
    .period_in        (period_in),
    .level_out        (level_out),
    .period_start_out (period_start_out)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // stimulus values as integers
  int s_vref, s_step, s_vmax, s_per;

  // behavioural model state
  int m_cnt;
  int cur_lo, cur_dwell, cur_per;
  int pend_lo, pend_dwell, pend_per;

  function automatic void plan(input int vref, input int step, input int vmax,
                               input int plen, output int lo, output int dwell,
                               output int per);
    longint num, q, frac;
    num = longint'(vref) + longint'(vmax);
    per = (plen < MIN_PER) ? MIN_PER : plen;
    if (num < 0) begin
      lo = 0; frac = 0;
    end else if (num >= longint'(step) * (LEVELS - 1)) begin
      lo = LEVELS - 1; frac = 0;
    end else begin
      q = (num * 256) / step;
      lo = int'(q / 256);
      frac = q % 256;
    end
    dwell = int'(((256 - frac) * per + 128) / 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic drive();
    vref_in   = REF_W'(s_vref);
    step_in   = REF_W'(s_step);
    vmax_in   = REF_W'(s_vmax);
    period_in = PER_W'(s_per);
  endtask

  // model the coming edge, then compare after it
  task automatic tick(input string req);
    int exp_lvl;
    if (m_cnt == cur_per - 1) begin
      m_cnt = 0;
      cur_lo = pend_lo; cur_dwell = pend_dwell; cur_per = pend_per;
      plan(s_vref, s_step, s_vmax, s_per, pend_lo, pend_dwell, pend_per);
    end else begin
      m_cnt++;
    end
    @(negedge clk);
    exp_lvl = (m_cnt < cur_dwell) ? cur_lo : cur_lo + 1;
    check(req, int'(level_out), exp_lvl);
    check("R6", int'(period_start_out), (m_cnt == 0) ? 1 : 0);
  endtask

  task automatic segment(input string req, input int vref, input int step,
                         input int vmax, input int plen, input int cycles);
    s_vref = vref; s_step = step; s_vmax = vmax; s_per = plen;
    drive();
    for (int i = 0; i < cycles; i++) tick(req);
  endtask

  initial begin
    rst_n = 1'b0;
    s_vref = 286; s_step = 200; s_vmax = 400; s_per = 100;
    drive();
    m_cnt = 0;
    cur_lo = 0; cur_dwell = MIN_PER; cur_per = MIN_PER;
    pend_lo = 0; pend_dwell = MIN_PER; pend_per = MIN_PER;
    // R7: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", int'(level_out), 0);
      check("R7", int'(period_start_out), 1);
    end
    rst_n = 1'b1;
    // R7: two floor periods, then R1 plan: 28.6/20/40 in 0.1 units -> 3 and 4
    for (int i = 0; i < 26; i++) tick("R7");
    segment("R1", 286, 200, 400, 100, 330);
    // R2: -31.6 V -> levels 0 and 1
    segment("R2", -316, 200, 400, 40, 140);
    // R2: fraction rounding just below the top
    segment("R2", 399, 200, 400, 257, 800);
    // R2: large fraction with the shortest period
    segment("R2", 395, 200, 400, 13, 60);
    // R8: exact level values
    segment("R8", 0, 200, 400, 50, 160);
    segment("R8", -200, 200, 400, 27, 90);
    // R4: exactly on top, far above, zero step
    segment("R4", 400, 200, 400, 30, 100);
    segment("R4", 32767, 200, 400, 30, 100);
    segment("R4", -400, 0, 400, 30, 100);
    // R3: below the floor
    segment("R3", -401, 200, 400, 30, 100);
    segment("R3", -32768, 100, 0, 20, 70);
    segment("R1", -400, 200, 400, 20, 70);
    // R6: period floor
    segment("R6", 150, 200, 400, 5, 60);
    segment("R6", 150, 200, 400, 0, 60);
    segment("R6", 150, 200, 400, 14, 60);
    // R5: single step change, latency of one full period
    segment("R5", -350, 200, 400, 25, 80);
    segment("R5", 350, 200, 400, 25, 80);
    // R9: reference redrawn on every clock
    s_step = 200; s_vmax = 400; s_per = 30;
    for (int i = 0; i < 400; i++) begin
      s_vref = int'($urandom_range(1000, 0)) - 500;
      drive();
      tick("R9");
    end
    // R2: mixed random plans
    for (int k = 0; k < 12; k++) begin
      int rv, rs, rm, rp;
      rs = int'($urandom_range(1000, 1));
      rm = int'($urandom_range(2000, 0));
      rv = int'($urandom_range(6000, 0)) - 3000;
      rp = int'($urandom_range(80, 10));
      segment("R2", rv, rs, rm, rp, 3 * ((rp < MIN_PER) ? MIN_PER : rp) + 5);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule